// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash. It takes one high-level request at a time and turns it into the chip-enable, output-enable and write-enable cycles the flash expects. A request carries a command code, a sector number, an offset, a data word and a byte/word mode flag. Every setup, pulse, access and reset interval is a count of clock ticks set by a parameter.

Most commands are written as a small program of bus cycles. Two unlock writes come first, then a command byte, and some commands add a further tail. Byte and word modes translate addresses differently. In byte mode the least significant address bit leaves on DQ15, and the upper data byte is released. A wait-ready request watches the flash ready/busy line with a tick limit. Each request ends with a one-cycle done pulse. A flag on that pulse reports whether the wait ran out of time.

Command writes use the unlock addresses in word terms: 0x555 for the first unlock and for the command byte, 0x2AA for the second unlock, and 0x55 for the query. In byte terms these are 0xAAA, 0x555 and 0xAA. Target cycles use the requested sector and offset.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, CE#, OE#, WE#, RESET#, WP# and BYTE# are high, no DQ bit is driven, and `reqReady` is high.
- R2: The command codes are READ=0, PROGRAM=1, SECT_ERASE=2, CHIP_ERASE=3, RESET=4, AUTOSEL=5, CFI=6, SUSPEND=7, RESUME=8, BYP_ENTER=9, BYP_EXIT=10, BYP_PROG=11, SECURE=12, WAIT_READY=13, HW_RESET=14, SET_WP=15. PROGRAM, SECT_ERASE, CHIP_ERASE, RESET, AUTOSEL, SECURE and BYP_ENTER begin with three writes: 0xAA to word address 0x555, then 0x55 to 0x2AA, then the command byte to 0x555. The command bytes are A0, 80, 80, F0, 90, 88 and 20, in that order of commands. PROGRAM then writes the request data to the target.
- R3: After their first three writes, both erase commands write 0xAA to 0x555 and 0x55 to 0x2AA. SECT_ERASE then writes 0x30 to the target sector and offset. CHIP_ERASE instead writes 0x10 to 0x555.
- R4: Each of these commands issues only the writes listed here, with no unlock prefix:
  - CFI writes 0x98 to word address 0x55.
  - SUSPEND writes 0xB0 to the target, and RESUME writes 0x30 to the target.
  - BYP_EXIT writes 0x90 and then 0xF0 to the target.
  - BYP_PROG writes 0xA0 to the target and then the request data.
- R5: In every write cycle, OE# is high and CE# is low while WE# is low. Every driven data bit stays stable for the whole WE# low pulse.
- R6: In byte mode, BYTE# is low, A14..A0 carry offset bits 15..1, DQ15 is driven with offset bit 0, and DQ14..DQ8 are never driven. In word mode, BYTE# is high and A14..A0 carry offset bits 14..0.
- R7: Target cycles put the sector number on A21..A15. Unlock, command and query cycles put zero there.
- R8: READ asserts CE# with WE# high and then OE#. It returns the sampled word on `respData`, or in byte mode DQ7..DQ0 zero-extended. No DQ bit other than DQ15 in byte mode is driven while OE# is low.
- R9: WAIT_READY ends with `respTimeout`=0 once RY/BY# is seen high. It ends with `respTimeout`=1 after the number of ticks given in the request data if RY/BY# stays low. `respTimeout` is never high without `respDone`.
- R10: HW_RESET holds RESET# low for exactly RESET_TICKS clock cycles and then completes.
- R11: SET_WP drives WP# to bit 0 of the request data. The level holds until the next SET_WP.
- R12: `reqReady` is low from the cycle after a request is accepted until its `respDone` pulse. A request presented meanwhile is ignored. `respDone` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request taken this cycle |
| reqCmd | input | 4 | Command code (see R2) |
| reqSector | input | SECT_W | Target sector |
| reqOffset | input | OFF_W+1 | Target offset in bytes (byte mode) or words (word mode) |
| reqData | input | 16 | Program data, WP# level, or wait tick limit |
| reqByteMode | input | 1 | 1 selects byte mode |
| respDone | output | 1 | One-cycle completion pulse |
| respTimeout | output | 1 | Wait ran out, valid with respDone |
| respData | output | 16 | Read result |
| flCeN | output | 1 | Flash chip enable, active low |
| flOeN | output | 1 | Flash output enable, active low |
| flWeN | output | 1 | Flash write enable, active low |
| flResetN | output | 1 | Flash hardware reset, active low |
| flWpN | output | 1 | Flash write protect, active low |
| flByteN | output | 1 | Flash byte-mode select, low for byte mode |
| flAddr | output | SECT_W+OFF_W | Flash address A21..A0 |
| flDqOut | output | 16 | Data bus value to drive |
| flDqOe | output | 16 | Per-bit drive enable for the data bus |
| flDqIn | input | 16 | Data bus value from the flash |
| flRyBy | input | 1 | Flash ready/busy, high when ready |

## Verification
The bench builds the block with SETUP_TICKS=2, PULSE_TICKS=3, ACCESS_TICKS=3 and RESET_TICKS=6, and keeps the default 7-bit sector and 15-bit offset widths. With these short intervals a full six-write erase finishes in a few dozen cycles, so every command program can be run in both byte and word modes. The full 22-bit address is still in play, so sector placement and the DQ15 low address bit are visible. Wait limits of 20 and 1000 ticks reach both the timeout exit and an early exit on RY/BY# rising partway through the wait.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    CMD_READ       = 4'd0,
    CMD_PROGRAM    = 4'd1,
    CMD_SECT_ERASE = 4'd2,
    CMD_CHIP_ERASE = 4'd3,
    CMD_RESET      = 4'd4,
    CMD_AUTOSEL    = 4'd5,
    CMD_CFI        = 4'd6,
    CMD_SUSPEND    = 4'd7,
    CMD_RESUME     = 4'd8,
    CMD_BYP_ENTER  = 4'd9,
    CMD_BYP_EXIT   = 4'd10,
    CMD_BYP_PROG   = 4'd11,
    CMD_SECURE     = 4'd12,
    CMD_WAIT_READY = 4'd13,
    CMD_HW_RESET   = 4'd14,
    CMD_SET_WP     = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    K_WR, K_RD, K_WAIT, K_HWRST, K_WP, K_END
  } kind_e;

  // Address source for a bus cycle
  typedef enum logic [1:0] {
    A_UNL1, A_UNL2, A_CFI, A_TGT
  } asel_e;

  typedef struct packed {
    kind_e       kind;
    asel_e       asel;
    logic        useData;
    logic [7:0]  code;
  } step_t;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic        latchReq;
    logic        loadAddr;
    asel_e       asel;
    logic        useData;
    logic [7:0]  code;
    logic        ceN;
    logic        oeN;
    logic        weN;
    logic        rstN;
    logic        drive;
    logic        capture;
    logic        setWp;
  } strobe_t;

  function automatic step_t mkWr(asel_e a, logic [7:0] c);
    step_t s;
    s.kind = K_WR;
    s.asel = a;
    s.useData = 1'b0;
    s.code = c;
    return s;
  endfunction

  function automatic step_t mkOp(kind_e k, logic useD);
    step_t s;
    s.kind = k;
    s.asel = A_TGT;
    s.useData = useD;
    s.code = 8'h00;
    return s;
  endfunction

  function automatic logic [7:0] thirdCode(cmd_e c);
    case (c)
      CMD_PROGRAM:    return 8'hA0;
      CMD_SECT_ERASE: return 8'h80;
      CMD_CHIP_ERASE: return 8'h80;
      CMD_RESET:      return 8'hF0;
      CMD_AUTOSEL:    return 8'h90;
      CMD_SECURE:     return 8'h88;
      CMD_BYP_ENTER:  return 8'h20;
      default:        return 8'h00;
    endcase
  endfunction

  // Bus-cycle program: step i of command c
  function automatic step_t seqStep(cmd_e c, logic [2:0] i);
    step_t s;
    logic  pre;
    s   = mkOp(K_END, 1'b0);
    pre = (c inside {CMD_PROGRAM, CMD_SECT_ERASE, CMD_CHIP_ERASE, CMD_RESET,
                     CMD_AUTOSEL, CMD_SECURE, CMD_BYP_ENTER});
    if (pre && i == 3'd0)      s = mkWr(A_UNL1, 8'hAA);
    else if (pre && i == 3'd1) s = mkWr(A_UNL2, 8'h55);
    else if (pre && i == 3'd2) s = mkWr(A_UNL1, thirdCode(c));
    else begin
      case (c)
        CMD_PROGRAM: if (i == 3'd3) s = mkOp(K_WR, 1'b1);
        CMD_SECT_ERASE, CMD_CHIP_ERASE: begin
          if (i == 3'd3)      s = mkWr(A_UNL1, 8'hAA);
          else if (i == 3'd4) s = mkWr(A_UNL2, 8'h55);
          else if (i == 3'd5) s = (c == CMD_SECT_ERASE) ? mkWr(A_TGT, 8'h30)
                                                        : mkWr(A_UNL1, 8'h10);
        end
        CMD_READ:       if (i == 3'd0) s = mkOp(K_RD, 1'b0);
        CMD_CFI:        if (i == 3'd0) s = mkWr(A_CFI, 8'h98);
        CMD_SUSPEND:    if (i == 3'd0) s = mkWr(A_TGT, 8'hB0);
        CMD_RESUME:     if (i == 3'd0) s = mkWr(A_TGT, 8'h30);
        CMD_BYP_EXIT: begin
          if (i == 3'd0)      s = mkWr(A_TGT, 8'h90);
          else if (i == 3'd1) s = mkWr(A_TGT, 8'hF0);
        end
        CMD_BYP_PROG: begin
          if (i == 3'd0)      s = mkWr(A_TGT, 8'hA0);
          else if (i == 3'd1) s = mkOp(K_WR, 1'b1);
        end
        CMD_WAIT_READY: if (i == 3'd0) s = mkOp(K_WAIT, 1'b0);
        CMD_HW_RESET:   if (i == 3'd0) s = mkOp(K_HWRST, 1'b0);
        CMD_SET_WP:     if (i == 3'd0) s = mkOp(K_WP, 1'b0);
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int SETUP_TICKS  = 3,
  parameter int PULSE_TICKS  = 4,
  parameter int ACCESS_TICKS = 5,
  parameter int RESET_TICKS  = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [3:0]  reqCmd,
  output logic        reqReady,
  input  logic        ryReady,
  input  logic [15:0] waitLimit,
  output strobe_t     strb,
  output logic        respDone,
  output logic        respTimeout
);

  localparam int MAX_T1 = (SETUP_TICKS > PULSE_TICKS) ? SETUP_TICKS : PULSE_TICKS;
  localparam int MAX_T2 = (ACCESS_TICKS > RESET_TICKS) ? ACCESS_TICKS : RESET_TICKS;
  localparam int MAX_T  = (MAX_T1 > MAX_T2) ? MAX_T1 : MAX_T2;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_W_CE, ST_W_WE, ST_W_HOLD, ST_STBY,
    ST_R_CE, ST_R_OE, ST_WAIT, ST_HWRST, ST_DONE
  } state_e;

  state_e             state;
  cmd_e               cmdQ;
  logic [2:0]         idx;
  logic [CNT_W-1:0]   cnt;
  logic [15:0]        waitCnt;
  logic               toFlag;
  step_t              step;

  assign step     = seqStep(cmdQ, idx);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.ceN     = 1'b1;
    strb.oeN     = 1'b1;
    strb.weN     = 1'b1;
    strb.rstN    = 1'b1;
    strb.asel    = step.asel;
    strb.code    = step.code;
    strb.useData = step.useData;
    case (state)
      ST_IDLE:   strb.latchReq = reqValid;
      ST_FETCH: begin
        strb.loadAddr = (step.kind == K_WR) || (step.kind == K_RD);
        strb.setWp    = (step.kind == K_WP);
      end
      ST_W_CE:   strb.ceN = 1'b0;
      ST_W_WE: begin
        strb.ceN   = 1'b0;
        strb.weN   = 1'b0;
        strb.drive = 1'b1;
      end
      ST_W_HOLD: begin
        strb.ceN   = 1'b0;
        strb.drive = 1'b1;
      end
      ST_R_CE:   strb.ceN = 1'b0;
      ST_R_OE: begin
        strb.ceN     = 1'b0;
        strb.oeN     = 1'b0;
        strb.capture = (cnt == '0);
      end
      ST_HWRST:  strb.rstN = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cmdQ        <= CMD_READ;
      idx         <= '0;
      cnt         <= '0;
      waitCnt     <= '0;
      toFlag      <= 1'b0;
      respDone    <= 1'b0;
      respTimeout <= 1'b0;
    end else begin
      respDone    <= 1'b0;
      respTimeout <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          cmdQ   <= cmd_e'(reqCmd);
          idx    <= '0;
          toFlag <= 1'b0;
          state  <= ST_FETCH;
        end
        ST_FETCH: begin
          case (step.kind)
            K_WR: begin
              cnt   <= CNT_W'(SETUP_TICKS - 1);
              state <= ST_W_CE;
            end
            K_RD: begin
              cnt   <= CNT_W'(SETUP_TICKS - 1);
              state <= ST_R_CE;
            end
            K_WAIT: begin
              waitCnt <= '0;
              state   <= ST_WAIT;
            end
            K_HWRST: begin
              cnt   <= CNT_W'(RESET_TICKS - 1);
              state <= ST_HWRST;
            end
            default: state <= ST_DONE;
          endcase
        end
        ST_W_CE: if (cnt == '0) begin
          cnt   <= CNT_W'(PULSE_TICKS - 1);
          state <= ST_W_WE;
        end else cnt <= cnt - 1'b1;
        ST_W_WE: if (cnt == '0) state <= ST_W_HOLD;
                 else cnt <= cnt - 1'b1;
        ST_W_HOLD: state <= ST_STBY;
        ST_STBY: begin
          idx   <= idx + 1'b1;
          state <= ST_FETCH;
        end
        ST_R_CE: if (cnt == '0) begin
          cnt   <= CNT_W'(ACCESS_TICKS - 1);
          state <= ST_R_OE;
        end else cnt <= cnt - 1'b1;
        ST_R_OE: if (cnt == '0) state <= ST_STBY;
                 else cnt <= cnt - 1'b1;
        ST_WAIT: begin
          if (ryReady) state <= ST_DONE;
          else if (waitCnt == waitLimit) begin
            toFlag <= 1'b1;
            state  <= ST_DONE;
          end else waitCnt <= waitCnt + 1'b1;
        end
        ST_HWRST: if (cnt == '0) state <= ST_DONE;
                  else cnt <= cnt - 1'b1;
        ST_DONE: begin
          respDone    <= 1'b1;
          respTimeout <= toFlag;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_timeout_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    respTimeout |-> respDone);

  assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

endmodule

// File: rtl/nor_seq_datapath.sv
module nor_seq_datapath
  import nor_seq_pkg::*;
#(
  parameter int SECT_W = 7,
  parameter int OFF_W  = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [SECT_W-1:0]       reqSector,
  input  logic [OFF_W:0]          reqOffset,
  input  logic [15:0]             reqData,
  input  logic                    reqByteMode,
  input  logic [15:0]             flDqIn,
  input  logic                    flRyBy,
  output logic                    flCeN,
  output logic                    flOeN,
  output logic                    flWeN,
  output logic                    flResetN,
  output logic                    flWpN,
  output logic                    flByteN,
  output logic [SECT_W+OFF_W-1:0] flAddr,
  output logic [15:0]             flDqOut,
  output logic [15:0]             flDqOe,
  output logic [15:0]             respData,
  output logic [15:0]             dataQ,
  output logic                    ryReady
);

  localparam logic [OFF_W-1:0] UNL1_A = OFF_W'(12'h555);
  localparam logic [OFF_W-1:0] UNL2_A = OFF_W'(12'h2AA);
  localparam logic [OFF_W-1:0] CFI_A  = OFF_W'(12'h055);

  logic [SECT_W-1:0] sectQ, sectAQ;
  logic [OFF_W:0]    offQ;
  logic              byteQ;
  logic [OFF_W-1:0]  aQ;
  logic              m1Q;
  logic [15:0]       wrDataQ;
  logic              driveQ;
  logic              rySync1;

  // Request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectQ <= '0;
      offQ  <= '0;
      dataQ <= '0;
      byteQ <= 1'b0;
    end else if (strb.latchReq) begin
      sectQ <= reqSector;
      offQ  <= reqOffset;
      dataQ <= reqData;
      byteQ <= reqByteMode;
    end
  end

  // Address and write data for the next bus cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectAQ  <= '0;
      aQ      <= '0;
      m1Q     <= 1'b0;
      wrDataQ <= '0;
    end else if (strb.loadAddr) begin
      wrDataQ <= strb.useData ? dataQ : {8'h00, strb.code};
      case (strb.asel)
        A_UNL1: begin sectAQ <= '0; aQ <= UNL1_A; m1Q <= 1'b0; end
        A_UNL2: begin sectAQ <= '0; aQ <= UNL2_A; m1Q <= 1'b1; end
        A_CFI:  begin sectAQ <= '0; aQ <= CFI_A;  m1Q <= 1'b0; end
        default: begin
          sectAQ <= sectQ;
          aQ     <= byteQ ? offQ[OFF_W:1] : offQ[OFF_W-1:0];
          m1Q    <= offQ[0];
        end
      endcase
    end
  end

  // Registered pin controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flCeN    <= 1'b1;
      flOeN    <= 1'b1;
      flWeN    <= 1'b1;
      flResetN <= 1'b1;
      flWpN    <= 1'b1;
      flByteN  <= 1'b1;
      driveQ   <= 1'b0;
      respData <= '0;
      rySync1  <= 1'b0;
      ryReady  <= 1'b0;
    end else begin
      flCeN    <= strb.ceN;
      flOeN    <= strb.oeN;
      flWeN    <= strb.weN;
      flResetN <= strb.rstN;
      flByteN  <= ~byteQ;
      driveQ   <= strb.drive;
      rySync1  <= flRyBy;
      ryReady  <= rySync1;
      if (strb.setWp)   flWpN    <= dataQ[0];
      if (strb.capture) respData <= byteQ ? {8'h00, flDqIn[7:0]} : flDqIn;
    end
  end

  assign flAddr  = {sectAQ, aQ};
  assign flDqOut = byteQ ? {m1Q, 7'b0, wrDataQ[7:0]} : wrDataQ;
  assign flDqOe  = byteQ ? {1'b1, 7'b0, {8{driveQ}}} : {16{driveQ}};

  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> !flCeN);

  assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> flOeN);

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && !$past(flWeN)) |-> $stable(flDqOut));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|flDqOe[14:0]) |-> flOeN);

  assert_upper_byte_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    !flByteN |-> (flDqOe[14:8] == 7'b0));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int SECT_W       = 7,
  parameter int OFF_W        = 15,
  parameter int SETUP_TICKS  = 3,
  parameter int PULSE_TICKS  = 4,
  parameter int ACCESS_TICKS = 5,
  parameter int RESET_TICKS  = 25
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [3:0]              reqCmd,
  input  logic [SECT_W-1:0]       reqSector,
  input  logic [OFF_W:0]          reqOffset,
  input  logic [15:0]             reqData,
  input  logic                    reqByteMode,
  output logic                    respDone,
  output logic                    respTimeout,
  output logic [15:0]             respData,
  output logic                    flCeN,
  output logic                    flOeN,
  output logic                    flWeN,
  output logic                    flResetN,
  output logic                    flWpN,
  output logic                    flByteN,
  output logic [SECT_W+OFF_W-1:0] flAddr,
  output logic [15:0]             flDqOut,
  output logic [15:0]             flDqOe,
  input  logic [15:0]             flDqIn,
  input  logic                    flRyBy
);

  strobe_t     strb;
  logic [15:0] dataQ;
  logic        ryReady;

  nor_seq_ctrl #(
    .SETUP_TICKS (SETUP_TICKS),
    .PULSE_TICKS (PULSE_TICKS),
    .ACCESS_TICKS(ACCESS_TICKS),
    .RESET_TICKS (RESET_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqCmd(reqCmd), .reqReady(reqReady),
    .ryReady(ryReady), .waitLimit(dataQ), .strb(strb),
    .respDone(respDone), .respTimeout(respTimeout)
  );

  nor_seq_datapath #(
    .SECT_W(SECT_W),
    .OFF_W (OFF_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqSector(reqSector), .reqOffset(reqOffset), .reqData(reqData),
    .reqByteMode(reqByteMode), .flDqIn(flDqIn), .flRyBy(flRyBy),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .flResetN(flResetN),
    .flWpN(flWpN), .flByteN(flByteN), .flAddr(flAddr),
    .flDqOut(flDqOut), .flDqOe(flDqOe), .respData(respData),
    .dataQ(dataQ), .ryReady(ryReady)
  );

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
  import nor_seq_pkg::*;

  localparam int RST_T = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqCmd = 4'd0;
  logic [6:0]  reqSector = 7'd0;
  logic [15:0] reqOffset = 16'd0;
  logic [15:0] reqData = 16'd0;
  logic        reqByteMode = 1'b0;
  logic        respDone, respTimeout;
  logic [15:0] respData;
  logic        flCeN, flOeN, flWeN, flResetN, flWpN, flByteN;
  logic [21:0] flAddr;
  logic [15:0] flDqOut, flDqOe, flDqIn;
  logic        flRyBy = 1'b0;

  int checks = 0, failures = 0, cyc = 0, viol = 0, lowCnt = 0, logN = 0;
  int startCyc = 0, doneCyc = 0;
  logic [21:0] logA [16];
  logic        logM1 [16];
  logic [15:0] logD [16];
  logic        prevWe = 1'b1;
  logic [15:0] prevDq = 16'h0;
  logic [15:0] gotData;
  logic        gotTo;

  always #10 clk = ~clk;

  nor_cmd_seq #(.SETUP_TICKS(2), .PULSE_TICKS(3), .ACCESS_TICKS(3), .RESET_TICKS(RST_T)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqSector(reqSector), .reqOffset(reqOffset),
    .reqData(reqData), .reqByteMode(reqByteMode), .respDone(respDone),
    .respTimeout(respTimeout), .respData(respData), .flCeN(flCeN),
    .flOeN(flOeN), .flWeN(flWeN), .flResetN(flResetN), .flWpN(flWpN),
    .flByteN(flByteN), .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
    .flDqIn(flDqIn), .flRyBy(flRyBy));

  function automatic logic [15:0] memWord(logic [21:0] a);
    return {a[7:0], a[15:8]} ^ {a[21:15], 9'h1A5};
  endfunction

  // Flash read model
  logic [15:0] mw;
  always_comb begin
    mw = memWord(flAddr);
    if (flCeN || flOeN) flDqIn = 16'h0000;
    else if (flByteN)   flDqIn = mw;
    else                flDqIn = {8'h00, flDqOut[15] ? mw[15:8] : mw[7:0]};
  end

  // Bus monitor
  always @(negedge clk) begin
    if (!flWeN && (flCeN || !flOeN)) viol++;
    if (!flWeN && flDqOe[7:0] != 8'hFF) viol++;
    if (!flByteN && flDqOe[14:8] != 7'h0) viol++;
    if (!flWeN && !prevWe && flDqOut != prevDq) viol++;
    if (!flResetN) lowCnt++;
    if (!prevWe && flWeN && logN < 16) begin
      logA[logN] = flAddr; logM1[logN] = flDqOut[15]; logD[logN] = flDqOut; logN++;
    end
    prevWe = flWeN; prevDq = flDqOut;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  task automatic chkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runCmd(logic [3:0] c, logic [6:0] s, logic [15:0] o, logic [15:0] d, bit bm);
    logN = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqCmd = c; reqSector = s; reqOffset = o; reqData = d; reqByteMode = bm;
    startCyc = cyc;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respDone) @(negedge clk);
    doneCyc = cyc; gotData = respData; gotTo = respTimeout;
  endtask

  // Expected write i: word address a (sector in top bits), A-1 bit, data
  task automatic expWr(string tag, int i, logic [21:0] a, bit m1, logic [15:0] d, bit bm);
    chkEq({tag, " addr"}, 32'(logA[i]), 32'(a));
    if (bm) begin
      chkEq({tag, " dq15"}, 32'(logM1[i]), 32'(m1));
      chkEq({tag, " data"}, 32'(logD[i][7:0]), 32'(d[7:0]));
    end else chkEq({tag, " data"}, 32'(logD[i]), 32'(d));
  endtask

  task automatic t_reset();
    chkEq("R1 pins", {26'h0, flCeN, flOeN, flWeN, flResetN, flWpN, flByteN}, 32'h3F);
    chkEq("R1 dq drive", 32'(flDqOe), 32'h0);
    chkEq("R1 ready", 32'(reqReady), 32'h1);
  endtask

  task automatic t_program_word();
    runCmd(CMD_PROGRAM, 7'h2A, 16'h1234, 16'hBEEF, 1'b0);
    chkEq("R2 program count", logN, 4);
    expWr("R2 unlock1", 0, 22'h555, 0, 16'h00AA, 0);
    expWr("R2 unlock2", 1, 22'h2AA, 0, 16'h0055, 0);
    expWr("R2 code A0", 2, 22'h555, 0, 16'h00A0, 0);
    expWr("R7 word target", 3, {7'h2A, 15'h1234}, 0, 16'hBEEF, 0);
  endtask

  task automatic t_program_byte();
    runCmd(CMD_PROGRAM, 7'h05, 16'h1235, 16'h0077, 1'b1);
    chkEq("R6 byte pin", 32'(flByteN), 32'h0);
    expWr("R6 byte unlock1", 0, 22'h555, 0, 16'h00AA, 1);
    expWr("R6 byte unlock2", 1, 22'h2AA, 1, 16'h0055, 1);
    expWr("R6 byte code", 2, 22'h555, 0, 16'h00A0, 1);
    expWr("R6 byte target", 3, {7'h05, 15'h091A}, 1, 16'h0077, 1);
  endtask

  task automatic t_erase();
    runCmd(CMD_SECT_ERASE, 7'h11, 16'h0040, 16'h0, 1'b0);
    chkEq("R3 sector erase count", logN, 6);
    expWr("R3 se code", 2, 22'h555, 0, 16'h0080, 0);
    expWr("R3 se unlock1b", 3, 22'h555, 0, 16'h00AA, 0);
    expWr("R3 se unlock2b", 4, 22'h2AA, 0, 16'h0055, 0);
    expWr("R3 se tail", 5, {7'h11, 15'h0040}, 0, 16'h0030, 0);
    runCmd(CMD_CHIP_ERASE, 7'h11, 16'h0040, 16'h0, 1'b1);
    chkEq("R3 chip erase count", logN, 6);
    expWr("R3 ce tail", 5, 22'h555, 0, 16'h0010, 1);
  endtask

  task automatic t_codes();
    logic [3:0] cl [4];
    logic [7:0] vl [4];
    cl = '{CMD_RESET, CMD_AUTOSEL, CMD_SECURE, CMD_BYP_ENTER};
    vl = '{8'hF0, 8'h90, 8'h88, 8'h20};
    for (int k = 0; k < 4; k++) begin
      runCmd(cl[k], 7'h3, 16'h10, 16'h0, 1'b0);
      chkEq("R2 code count", logN, 3);
      expWr("R2 code byte", 2, 22'h555, 0, {8'h00, vl[k]}, 0);
    end
  endtask

  task automatic t_single();
    runCmd(CMD_CFI, 7'h7F, 16'hFFFF, 16'h0, 1'b0);
    chkEq("R4 cfi count", logN, 1);
    expWr("R4 cfi word", 0, 22'h055, 0, 16'h0098, 0);
    runCmd(CMD_CFI, 7'h7F, 16'hFFFF, 16'h0, 1'b1);
    expWr("R4 cfi byte", 0, 22'h055, 0, 16'h0098, 1);
    runCmd(CMD_SUSPEND, 7'h09, 16'h0100, 16'h0, 1'b0);
    chkEq("R4 suspend count", logN, 1);
    expWr("R4 suspend", 0, {7'h09, 15'h0100}, 0, 16'h00B0, 0);
    runCmd(CMD_RESUME, 7'h09, 16'h0100, 16'h0, 1'b0);
    expWr("R4 resume", 0, {7'h09, 15'h0100}, 0, 16'h0030, 0);
    runCmd(CMD_BYP_EXIT, 7'h00, 16'h0002, 16'h0, 1'b0);
    chkEq("R4 bypass exit count", logN, 2);
    expWr("R4 exit 90", 0, 22'h2, 0, 16'h0090, 0);
    expWr("R4 exit F0", 1, 22'h2, 0, 16'h00F0, 0);
    runCmd(CMD_BYP_PROG, 7'h01, 16'h0777, 16'hA5C3, 1'b0);
    chkEq("R4 bypass prog count", logN, 2);
    expWr("R4 bprog A0", 0, {7'h01, 15'h0777}, 0, 16'h00A0, 0);
    expWr("R4 bprog data", 1, {7'h01, 15'h0777}, 0, 16'hA5C3, 0);
  endtask

  task automatic t_read();
    logic [15:0] w;
    runCmd(CMD_READ, 7'h03, 16'h0123, 16'h0, 1'b0);
    chkEq("R8 word read", 32'(gotData), 32'(memWord({7'h03, 15'h0123})));
    chkEq("R8 read no writes", logN, 0);
    w = memWord({7'h44, 15'h2000});
    runCmd(CMD_READ, 7'h44, 16'h4001, 16'h0, 1'b1);
    chkEq("R8 byte read odd", 32'(gotData), {24'h0, w[15:8]});
    runCmd(CMD_READ, 7'h44, 16'h4000, 16'h0, 1'b1);
    chkEq("R8 byte read even", 32'(gotData), {24'h0, w[7:0]});
  endtask

  task automatic t_wait();
    flRyBy = 1'b1;
    runCmd(CMD_WAIT_READY, 0, 0, 16'd50, 1'b0);
    chkEq("R9 ready already", 32'(gotTo), 32'h0);
    flRyBy = 1'b0;
    runCmd(CMD_WAIT_READY, 0, 0, 16'd20, 1'b0);
    chkEq("R9 timeout flag", 32'(gotTo), 32'h1);
    chkEq("R9 timeout not early", 32'(doneCyc - startCyc >= 20), 32'h1);
    chkEq("R9 timeout not late", 32'(doneCyc - startCyc <= 28), 32'h1);
    fork
      begin repeat (12) @(negedge clk); flRyBy = 1'b1; end
    join_none
    runCmd(CMD_WAIT_READY, 0, 0, 16'd1000, 1'b0);
    chkEq("R9 rise in time", 32'(gotTo), 32'h0);
    chkEq("R9 rise ends wait", 32'(doneCyc - startCyc < 30), 32'h1);
  endtask

  task automatic t_hwreset_wp();
    lowCnt = 0;
    runCmd(CMD_HW_RESET, 0, 0, 0, 1'b0);
    chkEq("R10 reset width", lowCnt, RST_T);
    chkEq("R10 reset released", 32'(flResetN), 32'h1);
    runCmd(CMD_SET_WP, 0, 0, 16'h0000, 1'b0);
    chkEq("R11 wp low", 32'(flWpN), 32'h0);
    runCmd(CMD_READ, 0, 16'h5, 16'hFFFF, 1'b0);
    chkEq("R11 wp held", 32'(flWpN), 32'h0);
    runCmd(CMD_SET_WP, 0, 0, 16'h0001, 1'b0);
    chkEq("R11 wp high", 32'(flWpN), 32'h1);
  endtask

  task automatic t_busy();
    logic seenReady;
    runCmd(CMD_RESUME, 0, 0, 0, 1'b0);
    logN = 0;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = CMD_PROGRAM; reqSector = 7'h1; reqOffset = 16'h9; reqData = 16'h1111; reqByteMode = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    seenReady = reqReady;
    reqValid = 1'b1; reqCmd = CMD_CFI;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respDone) @(negedge clk);
    repeat (40) @(negedge clk);
    chkEq("R12 busy ready low", 32'(seenReady), 32'h0);
    chkEq("R12 busy request ignored", logN, 4);
    chkEq("R12 still idle", 32'(reqReady), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program_word();
    t_program_byte();
    t_erase();
    t_codes();
    t_single();
    t_read();
    t_wait();
    t_hwreset_wp();
    t_busy();
    chkEq("R5 R6 bus rule violations", viol, 0);
    summary();
  end

endmodule